// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines into two request outputs for a processor: a normal request and a fast request. Software, through a simple 32-bit register bus, enables each line, can force it active, gives it a 4-bit priority, and decides whether it is routed to the normal or the fast output. A line is pending when it is enabled and either its input or its force bit is high.

For the normal path, a priority arbiter picks the pending normal line with the largest priority; on a tie the higher line number wins. A mask level can hide normal lines whose priority does not exceed it. Software reads the winner through a vector/status register, which carries the line number in its upper half and the winner's priority in its lower half, or all-ones in the upper half when nothing is eligible. The fast path has its own vector/status register that reports the highest-numbered pending fast line.

The bus has a byte address, a write strobe and write data; read data follows the address without a clock. A write takes effect at the clock edge on which the strobe is high.

Top module: `vic_top`

## Requirements
- R1: After reset the control word reads 0, the mask reads 0x1F, all enable, type, force and priority fields read 0, both vector/status registers read 0xFFFF0000 and both request outputs are low; the control word at 0x00 reads back the last value written.
- R2: Writing a value below 64 to 0x08 sets that line's enable bit and writing it to 0x0C clears it; a written value of 64 or more (all 32 bits compared) changes no enable bit.
- R3: In every paired register (enable 0x10/0x14, type 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64) the second (low) word bit n is line n and the first (high) word bit n is line n+32.
- R4: Line s has its 4-bit priority at bits [4*(s mod 8)+3 : 4*(s mod 8)] of the register at 0x20 + 4*(7 - s/8), so lines 56..63 are at 0x20 and lines 0..7 at 0x3C; these registers read back as written.
- R5: A line is pending when (input OR force) AND enable; pending lines with type bit 0 appear in the normal pending words and those with type bit 1 in the fast pending words; the pending words do not apply the mask.
- R6: The normal vector/status register at 0x40 returns in bits 31:16 the number of the eligible normal line with the largest priority, the higher number winning a tie, and that line's priority in bits 15:0; with no eligible line it reads 0xFFFF0000.
- R7: A pending normal line is eligible only if its priority is greater than the 5-bit mask at 0x04, except that a mask of 0x1F lets every pending normal line take part.
- R8: The normal request output is high exactly when at least one eligible normal line exists.
- R9: The fast request output is high exactly when any fast pending bit is set; the fast vector/status register at 0x44 returns the highest-numbered fast pending line in bits 31:16 and its priority in bits 15:0, or 0xFFFF0000 when none.
- R10: Writes to 0x40, 0x44, 0x48, 0x4C, 0x58, 0x5C, 0x60, 0x64 and writes to any address whose two low bits are not 00 change no register.
- R11: A register write is visible on reads and outputs in the cycle after its clock edge; a change on the source inputs is visible on the request outputs and read data in the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Level-sensitive interrupt lines, bit n is line n |
| irq_norm | output | 1 | Normal interrupt request, active high |
| irq_fast | output | 1 | Fast interrupt request, active high |

## Verification
Two delays matter here: a register write lands at the rising edge where the strobe is seen, so its effect on any read or request output is due one cycle after the write is driven, while source inputs pass straight through the pending, arbiter and read mux logic and are due with no clock at all. The bench drives every input on the falling edge and, for a write, waits for the following falling edge before reading, so every check of a write looks at the first cycle in which it may appear. Source-driven checks sample a few nanoseconds after the input changes within the same low clock phase, which shows both that the path needs no clock and that nothing settles later.

// File: rtl/vic_pkg.sv
// Package: shared sizes and register word indices of the interrupt controller.
// Assumes a 64-line block with byte addresses of 8 bits and 32-bit registers.
package vic_pkg;
    localparam int NSRC   = 64;
    localparam int PW     = 4;
    localparam int IW     = $clog2(NSRC);
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int MW     = 5;
    localparam int GROUPS = NSRC * PW / DW;

    // Word indices (byte address / 4)
    localparam logic [5:0] W_CTRL   = 6'd0;
    localparam logic [5:0] W_MASK   = 6'd1;
    localparam logic [5:0] W_ENNUM  = 6'd2;
    localparam logic [5:0] W_DISNUM = 6'd3;
    localparam logic [5:0] W_ENH    = 6'd4;
    localparam logic [5:0] W_ENL    = 6'd5;
    localparam logic [5:0] W_TYPH   = 6'd6;
    localparam logic [5:0] W_TYPL   = 6'd7;
    localparam logic [5:0] W_NVEC   = 6'd16;
    localparam logic [5:0] W_FVEC   = 6'd17;
    localparam logic [5:0] W_SRCH   = 6'd18;
    localparam logic [5:0] W_SRCL   = 6'd19;
    localparam logic [5:0] W_FRCH   = 6'd20;
    localparam logic [5:0] W_FRCL   = 6'd21;
    localparam logic [5:0] W_NPNDH  = 6'd22;
    localparam logic [5:0] W_NPNDL  = 6'd23;
    localparam logic [5:0] W_FPNDH  = 6'd24;
    localparam logic [5:0] W_FPNDL  = 6'd25;

    localparam logic [MW-1:0] MASK_OPEN = 5'h1F;
endpackage

// File: rtl/vic_regs.sv
// Module: software-visible state of the controller (control, mask, enable,
// type, force and packed priorities). Assumes a single write per cycle and
// word-aligned addresses; misaligned writes are dropped.
module vic_regs
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     ctrl,
    output logic [MW-1:0]     mask,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   typ,
    output logic [NSRC-1:0]   frc,
    output logic [NSRC*PW-1:0] prio_flat
);
    logic [5:0] widx;
    logic       aligned;
    logic       prio_hit;
    logic [2:0] grp;
    logic       num_ok;

    // Decode the word index, the priority window and the line-number range
    always_comb begin
        widx     = addr[7:2];
        aligned  = (addr[1:0] == 2'b00);
        prio_hit = (addr[7:5] == 3'b001);
        grp      = 3'd7 - addr[4:2];
        num_ok   = (wdata < DW'(NSRC));
    end

    // Register writes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            mask      <= MASK_OPEN;
            en        <= '0;
            typ       <= '0;
            frc       <= '0;
            prio_flat <= '0;
        end else if (wr_en && aligned) begin
            if (prio_hit) begin
                prio_flat[{grp, 5'b0} +: DW] <= wdata;
            end else begin
                case (widx)
                    W_CTRL:   ctrl <= wdata;
                    W_MASK:   mask <= wdata[MW-1:0];
                    W_ENNUM:  if (num_ok) en[wdata[IW-1:0]] <= 1'b1;
                    W_DISNUM: if (num_ok) en[wdata[IW-1:0]] <= 1'b0;
                    W_ENH:    en[NSRC-1:DW]  <= wdata;
                    W_ENL:    en[DW-1:0]     <= wdata;
                    W_TYPH:   typ[NSRC-1:DW] <= wdata;
                    W_TYPL:   typ[DW-1:0]    <= wdata;
                    W_FRCH:   frc[NSRC-1:DW] <= wdata;
                    W_FRCL:   frc[DW-1:0]    <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask == MASK_OPEN && en == '0 && typ == '0)); // R1
    AST_ENNUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h08 && wdata < 32'd64) |=> en[$past(wdata[5:0])]); // R2
    AST_DISNUM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h0C && wdata < 32'd64) |=> !en[$past(wdata[5:0])]); // R2
    AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 8'h08 || addr == 8'h0C) && wdata >= 32'd64) |=> $stable(en)); // R2
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((addr >= 8'h40 && addr <= 8'h4C) || (addr >= 8'h58 && addr <= 8'h64)
                   || addr[1:0] != 2'b00))
        |=> ($stable(en) && $stable(typ) && $stable(frc) && $stable(prio_flat)
             && $stable(mask) && $stable(ctrl))); // R10
endmodule

// File: rtl/vic_arbiter.sv
// Module: combinational winner search over NREQ requests. With USE_PRIO=1 the
// largest priority wins and ties go to the higher index; with USE_PRIO=0 the
// highest index wins. Reports the winner's index and priority.
module vic_arbiter #(
    parameter int NREQ     = 64,
    parameter int PWID     = 4,
    parameter bit USE_PRIO = 1'b1,
    localparam int IWID    = $clog2(NREQ)
) (
    input  logic [NREQ-1:0]      req,
    input  logic [NREQ*PWID-1:0] prio,
    output logic                 valid,
    output logic [IWID-1:0]      idx,
    output logic [PWID-1:0]      win_prio
);
    logic [NREQ*PWID-1:0] key;
    logic [PWID-1:0]      best;

    // Ranking key: the priorities or, for index-only ranking, all zero
    generate
        if (USE_PRIO) begin : g_prio_key
            assign key = prio;
        end else begin : g_index_key
            assign key = '0;
        end
    endgenerate

    // Scan upward; >= lets a later index take a tie
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && (!valid || key[i*PWID +: PWID] >= best)) begin
                valid = 1'b1;
                idx   = IWID'(i);
                best  = key[i*PWID +: PWID];
            end
        end
        win_prio = valid ? prio[idx*PWID +: PWID] : '0;
    end
endmodule

// File: rtl/vic_top.sv
// Module: top of the interrupt controller. Forms pending sets, applies the
// mask, runs a priority arbiter for normal lines and an index arbiter for
// fast lines, and serves register reads combinationally.
module vic_top
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [63:0]     src_in,
    output logic            irq_norm,
    output logic            irq_fast
);
    logic [DW-1:0]      ctrl;
    logic [MW-1:0]      mask;
    logic [NSRC-1:0]    en, typ, frc;
    logic [NSRC*PW-1:0] prio_flat;
    logic [NSRC-1:0]    pend, npend, fpend, nelig;
    logic               n_valid, f_valid;
    logic [IW-1:0]      n_idx, f_idx;
    logic [PW-1:0]      n_prio, f_prio;
    logic [DW-1:0]      nvec, fvec;
    logic [2:0]         rgrp;

    vic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .ctrl(ctrl), .mask(mask), .en(en), .typ(typ),
        .frc(frc), .prio_flat(prio_flat)
    );

    // Pending sets split by route
    always_comb begin
        pend  = (src_in | frc) & en;
        npend = pend & ~typ;
        fpend = pend & typ;
    end

    // Per-line mask test for the normal path
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_elig
            assign nelig[s] = npend[s] &&
                ((mask == MASK_OPEN) || ({1'b0, prio_flat[s*PW +: PW]} > mask));
        end
    endgenerate

    vic_arbiter #(.NREQ(NSRC), .PWID(PW), .USE_PRIO(1'b1)) u_narb (
        .req(nelig), .prio(prio_flat), .valid(n_valid), .idx(n_idx), .win_prio(n_prio)
    );

    vic_arbiter #(.NREQ(NSRC), .PWID(PW), .USE_PRIO(1'b0)) u_farb (
        .req(fpend), .prio(prio_flat), .valid(f_valid), .idx(f_idx), .win_prio(f_prio)
    );

    // Vector/status words and request outputs
    always_comb begin
        nvec     = n_valid ? {{(16-IW){1'b0}}, n_idx, {(16-PW){1'b0}}, n_prio} : 32'hFFFF_0000;
        fvec     = f_valid ? {{(16-IW){1'b0}}, f_idx, {(16-PW){1'b0}}, f_prio} : 32'hFFFF_0000;
        irq_norm = n_valid;
        irq_fast = f_valid;
    end

    // Read mux
    always_comb begin
        rgrp      = 3'd7 - bus_addr[4:2];
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr[7:5] == 3'b001) begin
                bus_rdata = prio_flat[{rgrp, 5'b0} +: DW];
            end else begin
                case (bus_addr[7:2])
                    W_CTRL:  bus_rdata = ctrl;
                    W_MASK:  bus_rdata = {{(DW-MW){1'b0}}, mask};
                    W_ENH:   bus_rdata = en[NSRC-1:DW];
                    W_ENL:   bus_rdata = en[DW-1:0];
                    W_TYPH:  bus_rdata = typ[NSRC-1:DW];
                    W_TYPL:  bus_rdata = typ[DW-1:0];
                    W_NVEC:  bus_rdata = nvec;
                    W_FVEC:  bus_rdata = fvec;
                    W_SRCH:  bus_rdata = src_in[NSRC-1:DW];
                    W_SRCL:  bus_rdata = src_in[DW-1:0];
                    W_FRCH:  bus_rdata = frc[NSRC-1:DW];
                    W_FRCL:  bus_rdata = frc[DW-1:0];
                    W_NPNDH: bus_rdata = npend[NSRC-1:DW];
                    W_NPNDL: bus_rdata = npend[DW-1:0];
                    W_FPNDH: bus_rdata = fpend[NSRC-1:DW];
                    W_FPNDL: bus_rdata = fpend[DW-1:0];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    AST_NWIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> (npend[n_idx] && !typ[n_idx])); // R6
    AST_NWIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> (mask == MASK_OPEN || {1'b0, n_prio} > mask)); // R7
    AST_NIRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> (npend != '0)); // R8
    AST_FWIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (fpend[f_idx] && typ[f_idx] && en[f_idx])); // R9
    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (npend & fpend) == '0); // R5
endmodule

// File: tb/vic_top_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module vic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_norm, irq_fast;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    vic_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h00, 32'h0);
        rd_chk("R1 mask", 8'h04, 32'h1F);
        rd_chk("R1 enh", 8'h10, 32'h0);
        rd_chk("R1 enl", 8'h14, 32'h0);
        rd_chk("R1 typl", 8'h1C, 32'h0);
        rd_chk("R1 prio g7", 8'h20, 32'h0);
        rd_chk("R1 prio g0", 8'h3C, 32'h0);
        rd_chk("R1 nvec", 8'h40, 32'hFFFF_0000);
        rd_chk("R1 fvec", 8'h44, 32'hFFFF_0000);
        chk("R1 irq_norm", {31'b0, irq_norm}, 32'h0);
        chk("R1 irq_fast", {31'b0, irq_fast}, 32'h0);
        wr(8'h00, 32'hA5A5_0F0F);
        rd_chk("R1 ctrl readback", 8'h00, 32'hA5A5_0F0F);
    endtask

    task automatic t_enable_num;
        wr(8'h08, 32'd5);
        rd_chk("R2 r11_ ennum 5 next cycle", 8'h14, 32'h20);
        rd_chk("R3 enh untouched", 8'h10, 32'h0);
        wr(8'h08, 32'd40);
        rd_chk("R3 ennum 40 in high word", 8'h10, 32'h100);
        wr(8'h08, 32'd64);
        rd_chk("R2 ennum 64 ignored hi", 8'h10, 32'h100);
        rd_chk("R2 ennum 64 ignored lo", 8'h14, 32'h20);
        wr(8'h08, 32'h106);
        rd_chk("R2 ennum 0x106 ignored", 8'h14, 32'h20);
        wr(8'h0C, 32'd5);
        rd_chk("R2 disnum 5", 8'h14, 32'h0);
        wr(8'h0C, 32'd104);
        rd_chk("R2 disnum 104 ignored", 8'h10, 32'h100);
    endtask

    task automatic t_pending;
        @(negedge clk);
        src_in[40] = 1'b1;
        #2;
        chk("R11 irq_norm same cycle", {31'b0, irq_norm}, 32'h1);
        rd_chk("R5 npend hi", 8'h58, 32'h100);
        rd_chk("R3 raw hi", 8'h48, 32'h100);
        rd_chk("R6 nvec line 40", 8'h40, 32'h0028_0000);
        src_in[3] = 1'b1;
        rd_chk("R5 raw lo", 8'h4C, 32'h8);
        rd_chk("R5 disabled not pending", 8'h5C, 32'h0);
        wr(8'h54, 32'h8);
        rd_chk("R5 force readback", 8'h54, 32'h8);
        wr(8'h08, 32'd3);
        src_in[3] = 1'b0;
        rd_chk("R5 force keeps pending", 8'h5C, 32'h8);
        rd_chk("R6 tie at prio 0 to line 40", 8'h40, 32'h0028_0000);
    endtask

    task automatic t_priority;
        wr(8'h3C, 32'h0000_7000);
        rd_chk("R4 group 0 readback", 8'h3C, 32'h0000_7000);
        rd_chk("R6 line 3 prio 7 wins", 8'h40, 32'h0003_0007);
        wr(8'h28, 32'h0000_0007);
        rd_chk("R4 group 5 at 0x28", 8'h28, 32'h7);
        rd_chk("R4 group 4 untouched", 8'h2C, 32'h0);
        rd_chk("R6 tie prio 7 to line 40", 8'h40, 32'h0028_0007);
        wr(8'h3C, 32'h0000_9000);
        rd_chk("R6 line 3 prio 9 wins", 8'h40, 32'h0003_0009);
    endtask

    task automatic t_mask;
        wr(8'h04, 32'd9);
        rd_chk("R7 mask 9 hides all", 8'h40, 32'hFFFF_0000);
        chk("R8 irq_norm low when masked", {31'b0, irq_norm}, 32'h0);
        rd_chk("R5 pending ignores mask", 8'h5C, 32'h8);
        wr(8'h04, 32'd8);
        rd_chk("R7 mask 8 passes line 3", 8'h40, 32'h0003_0009);
        chk("R8 irq_norm high", {31'b0, irq_norm}, 32'h1);
        wr(8'h04, 32'h0F);
        chk("R8 mask 0x0F blocks", {31'b0, irq_norm}, 32'h0);
        wr(8'h04, 32'h1F);
        rd_chk("R7 mask 0x1F open", 8'h40, 32'h0003_0009);
    endtask

    task automatic t_fast;
        wr(8'h18, 32'h100);
        rd_chk("R9 fpend hi", 8'h60, 32'h100);
        rd_chk("R5 npend hi cleared", 8'h58, 32'h0);
        chk("R9 irq_fast", {31'b0, irq_fast}, 32'h1);
        rd_chk("R9 fvec line 40", 8'h44, 32'h0028_0007);
        rd_chk("R6 nvec line 3", 8'h40, 32'h0003_0009);
        wr(8'h1C, 32'h8);
        rd_chk("R9 fpend lo", 8'h64, 32'h8);
        rd_chk("R9 highest number not prio", 8'h44, 32'h0028_0007);
        rd_chk("R6 no normal left", 8'h40, 32'hFFFF_0000);
        chk("R8 irq_norm low", {31'b0, irq_norm}, 32'h0);
        wr(8'h0C, 32'd40);
        rd_chk("R9 fvec line 3", 8'h44, 32'h0003_0009);
        chk("R9 irq_fast still", {31'b0, irq_fast}, 32'h1);
    endtask

    task automatic t_readonly;
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h5C, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h56, 32'hFFFF_FFFF);
        wr(8'h3D, 32'hFFFF_FFFF);
        rd_chk("R10 force lo kept", 8'h54, 32'h8);
        rd_chk("R10 force hi kept", 8'h50, 32'h0);
        rd_chk("R10 en hi kept", 8'h10, 32'h0);
        rd_chk("R10 en lo kept", 8'h14, 32'h8);
        rd_chk("R10 type hi kept", 8'h18, 32'h100);
        rd_chk("R10 prio kept", 8'h3C, 32'h0000_9000);
        rd_chk("R10 raw follows input", 8'h48, 32'h100);
        rd_chk("R10 fvec kept", 8'h44, 32'h0003_0009);
        rd_chk("R10 mask kept", 8'h04, 32'h1F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_num();
        t_pending();
        t_priority();
        t_mask();
        t_fast();
        t_readonly();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule